// File: doc/BRIEF.md
# I/O Readiness Predication Unit

This unit sits between instruction issue and the execution stages of a multi-threaded processor and decides, for each issued instruction, whether every I/O port it touches can complete its handshake. An instruction carries two source operand addresses and one destination address. Any of them may name an I/O port. The source ports are checked against their read-side acknowledge lines and the destination against its write-side acknowledge line. Addresses outside the port window always count as ready.

If every involved port is ready, the instruction passes through unchanged and a request pulse goes to each port it uses. If any involved port is not ready, the instruction is cancelled. The unit raises an annul flag for the controller, which re-issues the instruction later. It also replaces the instruction word with all zeros, which is the no-op encoding, and it sends no request to any port. This all-or-nothing rule stops a partially completed instruction from consuming data that would be lost when the instruction is re-issued.

The unit has two register stages. The first stage captures the issued operands. While the instruction sits in that stage, the acknowledge lines are selected and sampled. The second stage registers the verdict, the gated requests and the possibly-zeroed instruction.

Top module: `iopred_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `annul`, `out_instr`, `rd_req` and `wr_req` are all zero.
- R2: An address below `PORTS` names I/O port number `addr[PORT_W-1:0]`. Any other address is always ready, its acknowledge inputs have no effect, and it raises no request bit.
- R3: An instruction presented with `issue_valid` high before clock edge k appears on the outputs after edge k+1 with `out_valid` high. If every port it uses is ready, `out_instr` equals the issued word and `annul` is low.
- R4: If either source port's `rd_ack` bit is low, or the destination port's `wr_ack` bit is low, then `annul` is high and `out_instr` is all zeros.
- R5: Whenever `annul` is high, every bit of `rd_req` and `wr_req` is low.
- R6: For a ready instruction, `rd_req` has a bit set for exactly the I/O ports named by the two source operands. When both operands name the same port, only that one bit is set.
- R7: For a ready instruction, `wr_req` has exactly the destination port's bit set, or no bit if the destination is not an I/O port. This holds even when a source operand names the same port number.
- R8: The acknowledge lines are sampled in the cycle when the instruction is in the first stage, between edge k and edge k+1. Their values in any other cycle do not affect that instruction.
- R9: A cycle with `issue_valid` low produces, two edges later, `out_valid`, `annul`, `out_instr`, `rd_req` and `wr_req` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_instr | input | INSTR_W | Issued instruction word |
| rd_addr_a | input | ADDR_W | First source operand address |
| rd_addr_b | input | ADDR_W | Second source operand address |
| wr_addr | input | ADDR_W | Destination operand address |
| rd_ack | input | PORTS | Per-port read readiness |
| wr_ack | input | PORTS | Per-port write readiness |
| out_valid | output | 1 | Stage-two slot holds an instruction |
| annul | output | 1 | Instruction cancelled for re-issue |
| out_instr | output | INSTR_W | Issued word, or zero when annulled |
| rd_req | output | PORTS | Gated read request per port |
| wr_req | output | PORTS | Gated write request per port |

## Verification
The hardest situations to reach are those where only one of three accesses is blocked: the same port read twice, or read and written in one instruction, while a different port is not ready. These also depend on acknowledge values that differ between the issue cycle and the sampling cycle. The stimulus is a random stream that keeps most addresses inside the port window, so collisions happen often, and keeps each acknowledge bit mostly high, so single blocked accesses are common. The acknowledge lines are redrawn every cycle. Directed sequences add the cases where a port is not ready at issue but ready one cycle later, and the reverse.

// File: rtl/iopred_pkg.sv
package iopred_pkg;
    // Operand slots checked per instruction; the write slot uses the write-side acks.
    localparam int unsigned SLOT_RD_A = 0;
    localparam int unsigned SLOT_RD_B = 1;
    localparam int unsigned SLOT_WR   = 2;
    localparam int unsigned NUM_SLOTS = 3;
endpackage

// File: rtl/iopred_decode.sv
module iopred_decode #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned PORTS  = 4,
    parameter int unsigned PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_io,
    output logic [PORT_W-1:0] idx,
    output logic [PORTS-1:0]  onehot
);
    always_comb begin
        is_io  = (addr < ADDR_W'(PORTS));
        idx    = addr[PORT_W-1:0];
        onehot = is_io ? (PORTS'(1) << idx) : '0;
    end
endmodule

// File: rtl/iopred_acksel.sv
module iopred_acksel #(
    parameter int unsigned PORTS  = 4,
    parameter int unsigned PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic [PORTS-1:0]  ack,
    input  logic              is_io,
    input  logic [PORT_W-1:0] idx,
    output logic              ready
);
    // Same selection structure as the port data mux; non-port operands are ready.
    always_comb begin
        ready = is_io ? ack[idx] : 1'b1;
    end
endmodule

// File: rtl/iopred_unit.sv
module iopred_unit
    import iopred_pkg::*;
#(
    parameter int unsigned PORTS   = 4,
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned INSTR_W = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [INSTR_W-1:0] issue_instr,
    input  logic [ADDR_W-1:0]  rd_addr_a,
    input  logic [ADDR_W-1:0]  rd_addr_b,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [PORTS-1:0]   rd_ack,
    input  logic [PORTS-1:0]   wr_ack,
    output logic               out_valid,
    output logic               annul,
    output logic [INSTR_W-1:0] out_instr,
    output logic [PORTS-1:0]   rd_req,
    output logic [PORTS-1:0]   wr_req
);
    localparam int unsigned PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1;

    typedef struct packed {
        logic               valid;
        logic [INSTR_W-1:0] instr;
        logic [ADDR_W-1:0]  addr_a;
        logic [ADDR_W-1:0]  addr_b;
        logic [ADDR_W-1:0]  addr_w;
    } stage1_t;

    typedef struct packed {
        logic               valid;
        logic               annul;
        logic [INSTR_W-1:0] instr;
        logic [PORTS-1:0]   rd_req;
        logic [PORTS-1:0]   wr_req;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic [ADDR_W-1:0]    slot_addr [NUM_SLOTS];
    logic [PORTS-1:0]     slot_ack  [NUM_SLOTS];
    logic [PORTS-1:0]     slot_sel  [NUM_SLOTS];
    logic [PORT_W-1:0]    slot_idx  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_is_io;
    logic [NUM_SLOTS-1:0] slot_ready;

    assign slot_addr[SLOT_RD_A] = s1_q.addr_a;
    assign slot_addr[SLOT_RD_B] = s1_q.addr_b;
    assign slot_addr[SLOT_WR]   = s1_q.addr_w;
    assign slot_ack[SLOT_RD_A]  = rd_ack;
    assign slot_ack[SLOT_RD_B]  = rd_ack;
    assign slot_ack[SLOT_WR]    = wr_ack;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        iopred_decode #(
            .ADDR_W (ADDR_W),
            .PORTS  (PORTS),
            .PORT_W (PORT_W)
        ) u_dec (
            .addr   (slot_addr[s]),
            .is_io  (slot_is_io[s]),
            .idx    (slot_idx[s]),
            .onehot (slot_sel[s])
        );

        iopred_acksel #(
            .PORTS  (PORTS),
            .PORT_W (PORT_W)
        ) u_sel (
            .ack    (slot_ack[s]),
            .is_io  (slot_is_io[s]),
            .idx    (slot_idx[s]),
            .ready  (slot_ready[s])
        );
    end

    always_comb begin
        logic all_ready;
        logic fire;

        s1_d.valid  = issue_valid;
        s1_d.instr  = issue_instr;
        s1_d.addr_a = rd_addr_a;
        s1_d.addr_b = rd_addr_b;
        s1_d.addr_w = wr_addr;

        all_ready = &slot_ready;
        fire      = s1_q.valid & all_ready;

        s2_d.valid  = s1_q.valid;
        s2_d.annul  = s1_q.valid & ~all_ready;
        s2_d.instr  = fire ? s1_q.instr : '0;
        s2_d.rd_req = fire ? (slot_sel[SLOT_RD_A] | slot_sel[SLOT_RD_B]) : '0;
        s2_d.wr_req = fire ? slot_sel[SLOT_WR] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.valid;
    assign annul     = s2_q.annul;
    assign out_instr = s2_q.instr;
    assign rd_req    = s2_q.rd_req;
    assign wr_req    = s2_q.wr_req;
endmodule

// File: rtl/iopred_unit_chk.sv
module iopred_unit_chk #(
    parameter int unsigned PORTS   = 4,
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned INSTR_W = 36
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic [INSTR_W-1:0] issue_instr,
    input logic               out_valid,
    input logic               annul,
    input logic [INSTR_W-1:0] out_instr,
    input logic [PORTS-1:0]   rd_req,
    input logic [PORTS-1:0]   wr_req
);
    AST_ANNUL_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> (out_instr == '0)); // R4

    AST_ANNUL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> (rd_req == '0 && wr_req == '0)); // R5

    AST_RD_REQ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_req) <= 2); // R6

    AST_WR_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_req)); // R7

    AST_ANNUL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> out_valid); // R4

    AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!annul && rd_req == '0 && wr_req == '0 && out_instr == '0)); // R9

    AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(issue_valid, 2)); // R3

    AST_PASS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !annul) |-> (out_instr == $past(issue_instr, 2))); // R3
endmodule

bind iopred_unit iopred_unit_chk #(
    .PORTS   (PORTS),
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
) u_chk (.*);

// File: tb/tb_iopred_unit.sv
module tb_iopred_unit;
    localparam int unsigned PORTS   = 4;
    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned INSTR_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               issue_valid = 1'b0;
    logic [INSTR_W-1:0] issue_instr = '0;
    logic [ADDR_W-1:0]  rd_addr_a = '0;
    logic [ADDR_W-1:0]  rd_addr_b = '0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [PORTS-1:0]   rd_ack = '0;
    logic [PORTS-1:0]   wr_ack = '0;
    logic               out_valid;
    logic               annul;
    logic [INSTR_W-1:0] out_instr;
    logic [PORTS-1:0]   rd_req;
    logic [PORTS-1:0]   wr_req;

    iopred_unit #(.PORTS(PORTS), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_addr(wr_addr),
        .rd_ack(rd_ack), .wr_ack(wr_ack), .out_valid(out_valid), .annul(annul),
        .out_instr(out_instr), .rd_req(rd_req), .wr_req(wr_req)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit                 v;
        logic [INSTR_W-1:0] ins;
        logic [ADDR_W-1:0]  a, b, w;
        string              lab;
    } issue_t;

    issue_t hist0, hist1;
    logic [PORTS-1:0] last_rak, last_wak;

    function automatic logic [PORTS-1:0] port_bit(input logic [ADDR_W-1:0] x);
        return (x < PORTS) ? (PORTS'(1) << x[1:0]) : '0;
    endfunction

    function automatic bit port_ok(input logic [ADDR_W-1:0] x, input logic [PORTS-1:0] ack);
        return (x >= PORTS) || ack[x[1:0]];
    endfunction

    task automatic check_out(input issue_t h, input logic [PORTS-1:0] rak, input logic [PORTS-1:0] wak);
        bit               rdy;
        bit               e_an;
        logic [INSTR_W-1:0] e_ins;
        logic [PORTS-1:0] e_rd, e_wr;
        rdy   = port_ok(h.a, rak) && port_ok(h.b, rak) && port_ok(h.w, wak);
        e_an  = h.v && !rdy;
        e_ins = (h.v && rdy) ? h.ins : '0;
        e_rd  = (h.v && rdy) ? (port_bit(h.a) | port_bit(h.b)) : '0;
        e_wr  = (h.v && rdy) ? port_bit(h.w) : '0;
        checks++;
        if (out_valid !== h.v || annul !== e_an || out_instr !== e_ins ||
            rd_req !== e_rd || wr_req !== e_wr) begin
            errors++;
            $display("FAIL %s: got v=%0b an=%0b ins=%h rd=%b wr=%b exp v=%0b an=%0b ins=%h rd=%b wr=%b",
                     h.lab, out_valid, annul, out_instr, rd_req, wr_req,
                     h.v, e_an, e_ins, e_rd, e_wr);
        end
    endtask

    // Drives a new issue; the acks given belong to the instruction issued one step earlier.
    task automatic step(input bit v, input logic [INSTR_W-1:0] ins,
                        input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b,
                        input logic [ADDR_W-1:0] w,
                        input logic [PORTS-1:0] rak, input logic [PORTS-1:0] wak,
                        input string lab);
        @(negedge clk);
        check_out(hist1, last_rak, last_wak);
        hist1 = hist0;
        hist0.v = v; hist0.ins = ins; hist0.a = a; hist0.b = b; hist0.w = w;
        hist0.lab = v ? lab : "R9 bubble";
        issue_valid = v; issue_instr = ins;
        rd_addr_a = a; rd_addr_b = b; wr_addr = w;
        rd_ack = rak; wr_ack = wak;
        last_rak = rak; last_wak = wak;
    endtask

    function automatic logic [ADDR_W-1:0] rnd_addr();
        if ($urandom % 4 == 0) return ADDR_W'($urandom % 64);
        return ADDR_W'($urandom % 6);
    endfunction

    function automatic logic [PORTS-1:0] rnd_ack();
        logic [PORTS-1:0] r;
        for (int i = 0; i < PORTS; i++) r[i] = ($urandom % 5) != 0;
        return r;
    endfunction

    initial begin
        hist0.v = 0; hist0.lab = "R9 bubble"; hist0.ins = '0;
        hist0.a = '0; hist0.b = '0; hist0.w = '0;
        hist1 = hist0;
        last_rak = '0; last_wak = '0;
        void'($urandom(32'd4242));

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || annul !== 1'b0 || out_instr !== '0 || rd_req !== '0 || wr_req !== '0) begin
            errors++;
            $display("FAIL R1 reset: got v=%0b an=%0b ins=%h rd=%b wr=%b exp all zero",
                     out_valid, annul, out_instr, rd_req, wr_req);
        end
        rst_n = 1'b1;

        // R3 R6: two distinct read ports and a write port, all ready
        step(1, 16'h1234, 6'd1, 6'd2, 6'd3, 4'hF, 4'hF, "R3 R6 distinct ports ready");
        step(0, '0, '0, '0, '0, 4'hF, 4'hF, "");
        // R6: same port read twice
        step(1, 16'h2222, 6'd2, 6'd2, 6'd9, 4'hF, 4'hF, "R6 same port twice");
        step(0, '0, '0, '0, '0, 4'hF, 4'h0, "");
        // R7: write to a port that is also read
        step(1, 16'h3333, 6'd1, 6'd5, 6'd1, 4'hF, 4'hF, "R7 write equals read port");
        step(0, '0, '0, '0, '0, 4'hF, 4'hF, "");
        // R4 R5: second read not ready
        step(1, 16'h4444, 6'd0, 6'd3, 6'd2, 4'hF, 4'hF, "R4 R5 read B blocked");
        step(0, '0, '0, '0, '0, 4'b0111, 4'hF, "");
        // R4 R5: only the write destination not ready
        step(1, 16'h5555, 6'd0, 6'd1, 6'd2, 4'hF, 4'hF, "R4 R5 write blocked");
        step(0, '0, '0, '0, '0, 4'hF, 4'b1011, "");
        // R4: same port read twice, that port not ready
        step(1, 16'h5A5A, 6'd3, 6'd3, 6'd50, 4'hF, 4'hF, "R4 doubled read blocked");
        step(0, '0, '0, '0, '0, 4'b0111, 4'hF, "");
        // R2: no operand in the port window, all acks low
        step(1, 16'h6666, 6'd10, 6'd63, 6'd40, 4'hF, 4'hF, "R2 non-port operands ignore acks");
        step(0, '0, '0, '0, '0, 4'h0, 4'h0, "");
        // R8: acks low in issue cycle, high in sample cycle -> passes
        step(0, '0, '0, '0, '0, 4'hF, 4'hF, "");
        step(1, 16'h7777, 6'd0, 6'd1, 6'd2, 4'h0, 4'h0, "R8 low at issue high at sample");
        step(0, '0, '0, '0, '0, 4'hF, 4'hF, "");
        step(0, '0, '0, '0, '0, 4'h0, 4'h0, "");
        // R8: acks high at issue, low at sample, high afterwards -> annulled
        step(1, 16'h8888, 6'd0, 6'd1, 6'd2, 4'hF, 4'hF, "R8 high at issue low at sample");
        step(0, '0, '0, '0, '0, 4'h0, 4'h0, "");
        step(0, '0, '0, '0, '0, 4'hF, 4'hF, "");
        // R3 back-to-back ready instructions
        step(1, 16'h9001, 6'd0, 6'd7, 6'd3, 4'hF, 4'hF, "R3 back-to-back first");
        step(1, 16'h9002, 6'd3, 6'd0, 6'd0, 4'hF, 4'hF, "R3 back-to-back second");
        step(0, '0, '0, '0, '0, 4'hF, 4'hF, "");

        // R3/R4/R5/R6/R7 random stream
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 8) != 0, INSTR_W'($urandom), rnd_addr(), rnd_addr(), rnd_addr(),
                 rnd_ack(), rnd_ack(), "R3/R4/R5/R6/R7 random");
        end
        step(0, '0, '0, '0, '0, 4'hF, 4'hF, "");
        step(0, '0, '0, '0, '0, 4'hF, 4'hF, "");

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule